// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides, once per machine cycle, whether the core must break into a service routine and where that routine starts. Eight request flags are captured at a fixed sample point in the machine cycle. A later poll compares only that captured snapshot against two priority levels and the levels already in service. It then offers the core a hardware call with a 16-bit start address. The core stacks the program counter and decodes instructions. It tells the block when the current cycle is the last one of an instruction, when a return-from-interrupt is executing, and when the instruction touches the enable or priority registers.

The call leaves the block on a valid/ready pair. `call_valid` rises with `call_vector`, and both hold unchanged until the core raises `call_ready`. While a call is outstanding, no new decision is made. When the call is accepted, the block pulses a clear to the taken source, but only if that source is one whose flag clears itself on vectoring. Service state is one bit per level. A high-level source may preempt a low-level routine. Only a return-from-interrupt lowers the service state, and it always clears the highest level in service.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Each source's flag is captured, gated by its enable and the global enable, only in a cycle where `phase_strobe` is 1. A decision uses only the last captured snapshot. A flag that rises after the strobe is not seen. A flag that falls after the strobe is still served.
- R2: Every poll is fresh. A captured source that was blocked, and whose flag is 0 at the next strobe, is never called.
- R3: A high-level source is taken only when bit 1 of `in_service` is 0. A low-level source is taken only when `in_service` is 0. A high source preempts a low routine.
- R4: A call is decided only in a cycle with `instr_last` = 1. `call_valid` rises at the clock edge that ends that cycle.
- R5: No call is decided in a cycle where `reti_exec` or `ie_ip_access` is 1.
- R6: Source index i (bit i of the flag, enable and priority vectors) maps to these addresses: 0→0x0003, 1→0x000B, 2→0x0013, 3→0x001B, 4→0x0023, 5→0x002B, 6→0x0043, 7→0x004B.
- R7: Any pending high source (`src_priority` bit = 1) wins over every low source. Within a level, the lowest index wins.
- R8: A source is considered only when its `src_enable` bit and `global_enable` are both 1 at the strobe.
- R9: `call_valid` and `call_vector` hold steady until a cycle with `call_ready` = 1. `call_valid` is 0 from the next edge.
- R10: Taking a call sets `in_service` bit 1 (high) or bit 0 (low). A cycle with `reti_exec` and `instr_last` both 1 clears the highest set bit. Without it, the bits stay set.
- R11: In the accepting cycle, `flag_clear` has the taken source's bit set only for indices 0 to 3. It is all zero otherwise.
- R12: After reset, `call_valid`, `flag_clear` and `in_service` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_strobe | input | 1 | Sample point of the machine cycle |
| req_flags | input | 8 | Raw request flags, index = polling order |
| src_enable | input | 8 | Per-source enable |
| global_enable | input | 1 | Master enable |
| src_priority | input | 8 | Per-source level, 1 = high |
| instr_last | input | 1 | Final cycle of current instruction |
| reti_exec | input | 1 | Return-from-interrupt executing |
| ie_ip_access | input | 1 | Current instruction accesses enable/priority registers |
| call_ready | input | 1 | Core accepts the hardware call |
| call_valid | output | 1 | Hardware call requested |
| call_vector | output | 16 | Start address of the routine |
| flag_clear | output | 8 | One-cycle clear for a self-clearing source |
| in_service | output | 2 | Bit 1 = high level active, bit 0 = low level active |

## Verification
Each source is raised alone so that every address and every clear pattern can be told apart. All flags together under different priority masks separate the in-level order from the level rule. Flags that rise or fall between strobe and poll distinguish the captured snapshot from the live flags. A source that is blocked and then dropped shows that nothing is remembered across polls. A sequence of low service, refused same-level work, high preemption and two returns covers the in-service rules.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_W      = 16;
  localparam int unsigned VEC_BASE   = 3;
  localparam int unsigned VEC_STRIDE = 8;
  localparam int unsigned GAP_AFTER  = 6;  // index where the address map skips slots
  localparam int unsigned GAP_SLOTS  = 2;

  function automatic logic [VEC_W-1:0] vec_addr(input int unsigned idx);
    int unsigned slot;
    slot = (idx >= GAP_AFTER) ? idx + GAP_SLOTS : idx;
    return VEC_W'(VEC_BASE + VEC_STRIDE * slot);
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  input  logic         gen,
  output logic [N-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap <= '0;
    else if (strobe) snap <= flags & en & {N{gen}};
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       ret_done,
  output logic [1:0] active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 2'b00;
    end else if (take) begin
      if (take_hi) active[1] <= 1'b1;
      else         active[0] <= 1'b1;
    end else if (ret_done) begin
      if (active[1]) active[1] <= 1'b0;
      else           active[0] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NUM_SRC         = 8,
  parameter logic [7:0]  SELF_CLEAR_MASK = 8'h0F,
  localparam int unsigned IW = $clog2(NUM_SRC),
  localparam int unsigned VW = irq_vec_pkg::VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_strobe,
  input  logic [NUM_SRC-1:0] req_flags,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic               global_enable,
  input  logic [NUM_SRC-1:0] src_priority,
  input  logic               instr_last,
  input  logic               reti_exec,
  input  logic               ie_ip_access,
  input  logic               call_ready,
  output logic               call_valid,
  output logic [VW-1:0]      call_vector,
  output logic [NUM_SRC-1:0] flag_clear,
  output logic [1:0]         in_service
);
  logic [NUM_SRC-1:0] snap;
  logic               hi_hit, lo_hit;
  logic [IW-1:0]      hi_idx, lo_idx, win_idx, taken_idx;
  logic               level_ok, take, accept;

  irq_sampler #(.N(NUM_SRC)) i_sampler (
    .clk(clk), .rst_n(rst_n), .strobe(phase_strobe),
    .flags(req_flags), .en(src_enable), .gen(global_enable), .snap(snap)
  );

  irq_first_set #(.N(NUM_SRC)) i_pick_hi (
    .req(snap & src_priority), .hit(hi_hit), .idx(hi_idx)
  );
  irq_first_set #(.N(NUM_SRC)) i_pick_lo (
    .req(snap & ~src_priority), .hit(lo_hit), .idx(lo_idx)
  );

  assign win_idx  = hi_hit ? hi_idx : lo_idx;
  assign level_ok = hi_hit ? !in_service[1] : (lo_hit && in_service == 2'b00);
  assign take     = instr_last && !reti_exec && !ie_ip_access && !call_valid && level_ok;
  assign accept   = call_valid && call_ready;

  irq_level_track i_levels (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(hi_hit),
    .ret_done(reti_exec && instr_last), .active(in_service)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_valid  <= 1'b0;
      call_vector <= '0;
      taken_idx   <= '0;
    end else if (take) begin
      call_valid  <= 1'b1;
      call_vector <= irq_vec_pkg::vec_addr(int'(win_idx));
      taken_idx   <= win_idx;
    end else if (accept) begin
      call_valid  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign flag_clear[g] = accept && (taken_idx == IW'(g)) && SELF_CLEAR_MASK[g];
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_last,
  input logic               reti_exec,
  input logic               ie_ip_access,
  input logic               call_ready,
  input logic               call_valid,
  input logic [15:0]        call_vector,
  input logic [NUM_SRC-1:0] flag_clear,
  input logic [1:0]         in_service
);
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !call_ready |=> call_valid && $stable(call_vector));

  a_r4_call_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(instr_last));

  a_r5_no_call_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> !$past(reti_exec) && !$past(ie_ip_access));

  a_r10_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> in_service != 2'b00);

  a_r10_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    reti_exec && instr_last && in_service != 2'b00
      |=> $countones(in_service) + 1 == $countones($past(in_service)));

  a_r11_clear_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear != '0 |-> call_valid && call_ready);

  a_r11_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clear));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .instr_last(instr_last), .reti_exec(reti_exec),
  .ie_ip_access(ie_ip_access), .call_ready(call_ready), .call_valid(call_valid),
  .call_vector(call_vector), .flag_clear(flag_clear), .in_service(in_service)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_strobe = 1'b0;
  logic [7:0]  req_flags = '0, src_enable = '0, src_priority = '0;
  logic        global_enable = 1'b0, instr_last = 1'b0, reti_exec = 1'b0;
  logic        ie_ip_access = 1'b0, call_ready = 1'b0;
  logic        call_valid;
  logic [15:0] call_vector;
  logic [7:0]  flag_clear;
  logic [1:0]  in_service;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .phase_strobe(phase_strobe), .req_flags(req_flags),
    .src_enable(src_enable), .global_enable(global_enable), .src_priority(src_priority),
    .instr_last(instr_last), .reti_exec(reti_exec), .ie_ip_access(ie_ip_access),
    .call_ready(call_ready), .call_valid(call_valid), .call_vector(call_vector),
    .flag_clear(flag_clear), .in_service(in_service)
  );

  function automatic logic [15:0] exp_vec(input int i);
    case (i)
      0: return 16'h0003; 1: return 16'h000B; 2: return 16'h0013; 3: return 16'h001B;
      4: return 16'h0023; 5: return 16'h002B; 6: return 16'h0043; default: return 16'h004B;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; phase_strobe = 0; req_flags = '0; instr_last = 0; reti_exec = 0;
    ie_ip_access = 0; call_ready = 0; src_enable = 8'hFF; global_enable = 1; src_priority = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic latch(input logic [7:0] f);
    req_flags = f; phase_strobe = 1'b1;
    @(negedge clk);
    phase_strobe = 1'b0;
  endtask

  task automatic poll(input logic blk_reti, input logic blk_ie);
    instr_last = 1'b1; reti_exec = blk_reti; ie_ip_access = blk_ie;
    @(negedge clk);
    instr_last = 1'b0; reti_exec = 1'b0; ie_ip_access = 1'b0;
  endtask

  task automatic accept(input string req, input logic [7:0] exp_clr);
    call_ready = 1'b1;
    #1 chk(req, flag_clear, exp_clr);
    @(negedge clk);
    call_ready = 1'b0;
    chk("R9 valid drops after accept", call_valid, 0);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R12 call_valid", call_valid, 0);
    chk("R12 flag_clear", flag_clear, 0);
    chk("R12 in_service", in_service, 0);
  endtask

  task automatic t_vectors();
    for (int i = 0; i < 8; i++) begin
      reset_dut();
      latch(8'(1 << i));
      poll(0, 0);
      chk("R6 valid", call_valid, 1);
      chk("R6 vector", call_vector, exp_vec(i));
      accept("R11 flag_clear", (i < 4) ? 8'(1 << i) : 8'h00);
    end
  endtask

  task automatic t_order();
    reset_dut();
    latch(8'hFF); poll(0, 0);
    chk("R7 lowest index in level", call_vector, exp_vec(0));
    reset_dut();
    src_priority = 8'h80; latch(8'hFF); poll(0, 0);
    chk("R7 high beats low", call_vector, exp_vec(7));
    chk("R10 high level marked", in_service, 2'b10);
    reset_dut();
    src_priority = 8'h24; latch(8'hFF); poll(0, 0);
    chk("R7 order among high", call_vector, exp_vec(2));
  endtask

  task automatic t_sample();
    reset_dut();
    latch(8'h00);
    req_flags = 8'h01; poll(0, 0);
    chk("R1 late flag unseen", call_valid, 0);
    latch(8'h01);
    req_flags = 8'h00; poll(0, 0);
    chk("R1 snapshot served", call_valid, 1);
    chk("R1 vector", call_vector, exp_vec(0));
  endtask

  task automatic t_forget();
    reset_dut();
    latch(8'h02); poll(0, 1);
    chk("R5 register access blocks", call_valid, 0);
    latch(8'h00); poll(0, 0);
    chk("R2 dropped flag forgotten", call_valid, 0);
    reset_dut();
    latch(8'h02); poll(1, 0);
    chk("R5 reti blocks", call_valid, 0);
  endtask

  task automatic t_last();
    reset_dut();
    latch(8'h08);
    repeat (3) @(negedge clk);
    chk("R4 no call mid-instruction", call_valid, 0);
    poll(0, 0);
    chk("R4 call at last cycle", call_valid, 1);
    chk("R4 vector", call_vector, exp_vec(3));
  endtask

  task automatic t_enable();
    reset_dut();
    src_enable = 8'hEF; latch(8'h10); poll(0, 0);
    chk("R8 source disabled", call_valid, 0);
    src_enable = 8'hFF; global_enable = 0; latch(8'h10); poll(0, 0);
    chk("R8 global disabled", call_valid, 0);
    global_enable = 1; latch(8'h10); poll(0, 0);
    chk("R8 enabled taken", call_vector, exp_vec(4));
  endtask

  task automatic t_handshake();
    reset_dut();
    latch(8'h40); poll(0, 0);
    repeat (3) @(negedge clk);
    chk("R9 held valid", call_valid, 1);
    chk("R9 held vector", call_vector, exp_vec(6));
    src_priority = 8'h01; latch(8'h01); poll(0, 0);
    chk("R9 no replace while pending", call_vector, exp_vec(6));
    accept("R11 no clear for index 6", 8'h00);
  endtask

  task automatic t_levels();
    reset_dut();
    latch(8'h08); poll(0, 0); accept("R11 clear index 3", 8'h08);
    chk("R10 low marked", in_service, 2'b01);
    latch(8'h10); poll(0, 0);
    chk("R3 equal low refused", call_valid, 0);
    src_priority = 8'h60; latch(8'h20); poll(0, 0);
    chk("R3 high preempts low", call_vector, exp_vec(5));
    accept("R11 no clear for index 5", 8'h00);
    chk("R10 both levels", in_service, 2'b11);
    latch(8'h40); poll(0, 0);
    chk("R3 equal high refused", call_valid, 0);
    repeat (4) @(negedge clk);
    chk("R10 held without reti", in_service, 2'b11);
    latch(8'h00);
    poll(1, 0);
    chk("R10 reti clears high", in_service, 2'b01);
    poll(1, 0);
    chk("R10 reti clears low", in_service, 2'b00);
    latch(8'h10); poll(0, 0);
    chk("R3 low taken after return", call_vector, exp_vec(4));
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_order();
    t_sample();
    t_forget();
    t_last();
    t_enable();
    t_handshake();
    t_levels();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule